// File: doc/BRIEF.md
# Seven-Segment Digit Write Port

This block lets a processor load characters into a bank of seven-segment digit registers. The processor presents a four-bit character code and a digit address, then pulls two active-low select lines low together. While both selects are low, the block keeps copying code and address into a holding stage. When either select goes high again, the held code is turned into a segment pattern inside the block and written into the register of the addressed digit. All digit registers drive a flat segment bus continuously.

The selects are asynchronous to the block clock and pass through a configurable synchroniser. A small controller has three named states. ST_IDLE waits for both selects low. The transition idle→capture is taken when the synchronised both-low condition appears. ST_CAPTURE copies code and address on every cycle. The transition capture→commit is taken on the first cycle in which either synchronised select is high. ST_COMMIT lasts one cycle and issues the write. From there, the transition commit→capture is taken if both selects are low again, and commit→idle otherwise.

Top module: `segwr_port`

## Requirements
- R1: A write happens only after a period in which both selects were low together. Lowering and raising a single select leaves every segment output unchanged.
- R2: Exactly one write happens per both-low period. This holds whether select A rises first, select B rises first, or both rise on the same clock.
- R3: Digit field k occupies `seg_o[7k+6:7k]`. Address value a writes field 3−a, so address 0 writes the highest field and address 3 writes field 0.
- R4: The code input is plain binary, with bit 0 least significant.
- R5: Within each field, bit 0 is segment a, then b, c, d, e, f, and bit 6 is segment g. Codes 0 to 9 give the digit shapes 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: Code 10 gives dash (40, segment g only), 11 gives E (79), 12 gives H (76), 13 gives L (38), 14 gives P (73), and 15 gives blank (00).
- R7: A write changes only the addressed field. The other fields keep their contents.
- R8: While reset is low, and after it is released until the first write, all segment outputs are 0.
- R9: With two synchroniser stages, the new pattern appears after the fourth rising clock edge that follows the releasing select edge, and not after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | First active-low select |
| sel_b_n | input | 1 | Second active-low select |
| code_i | input | 4 | Character code, binary |
| addr_i | input | 2 | Digit address (reversed mapping) |
| seg_o | output | 28 | Segment-on bits, seven per digit |

## Verification
The bench builds the block with its defaults: four digits and two synchroniser stages. With two stages the release-to-update latency is a fixed four edges, so the bench can check the old value after the third edge and the new one after the fourth. With four digits and a two-bit address, a sweep of all 16 codes over every address covers the whole reversed address map and the full character set. Random writes mix the three release orders and include single-select pulses that must have no effect.

// File: rtl/segwr_pkg.sv
package segwr_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_COMMIT  = 2'd2
    } wr_state_e;
endpackage

// File: rtl/segwr_sync.sv
module segwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[0] <= '1;
                    else        pipe_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[s] <= '1;
                    else        pipe_q[s] <= pipe_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/segwr_ctrl.sv
module segwr_ctrl
    import segwr_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_n_s,
    input  logic [CODE_W-1:0] code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              commit_o,
    output logic [CODE_W-1:0] code_o,
    output logic [ADDR_W-1:0] addr_o,
    output wr_state_e         state_o
);
    wr_state_e state_q, state_d;
    logic      both_low;

    assign both_low = ~sel_n_s[0] & ~sel_n_s[1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (both_low)  state_d = ST_CAPTURE;
            ST_CAPTURE: if (!both_low) state_d = ST_COMMIT;
            ST_COMMIT:  state_d = both_low ? ST_CAPTURE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            addr_o <= '0;
        end else if (both_low) begin
            code_o <= code_i;
            addr_o <= addr_i;
        end
    end

    assign commit_o = (state_q == ST_COMMIT);
    assign state_o  = state_q;
endmodule

// File: rtl/segwr_glyph.sv
module segwr_glyph
    import segwr_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_W-1:0]  seg_o
);
    always_comb begin
        unique case (code_i)
            4'd0:  seg_o = 7'h3F;
            4'd1:  seg_o = 7'h06;
            4'd2:  seg_o = 7'h5B;
            4'd3:  seg_o = 7'h4F;
            4'd4:  seg_o = 7'h66;
            4'd5:  seg_o = 7'h6D;
            4'd6:  seg_o = 7'h7D;
            4'd7:  seg_o = 7'h07;
            4'd8:  seg_o = 7'h7F;
            4'd9:  seg_o = 7'h6F;
            4'd10: seg_o = 7'h40;
            4'd11: seg_o = 7'h79;
            4'd12: seg_o = 7'h76;
            4'd13: seg_o = 7'h38;
            4'd14: seg_o = 7'h73;
            default: seg_o = 7'h00;
        endcase
    end
endmodule

// File: rtl/segwr_bank.sv
module segwr_bank
    import segwr_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       field_i,
    input  logic [SEG_W-1:0]        pat_i,
    output logic [DIGITS*SEG_W-1:0] seg_o
);
    generate
        for (genvar k = 0; k < DIGITS; k++) begin : g_digit
            logic [SEG_W-1:0] pat_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                   pat_q <= '0;
                else if (we_i && field_i == ADDR_W'(k))       pat_q <= pat_i;
            end
            assign seg_o[k*SEG_W +: SEG_W] = pat_q;
        end
    endgenerate
endmodule

// File: rtl/segwr_port.sv
module segwr_port
    import segwr_pkg::*;
#(
    parameter  int DIGITS      = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(DIGITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic [CODE_W-1:0]       code_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [DIGITS*SEG_W-1:0] seg_o
);
    logic [1:0]        sel_s;
    logic              commit_w;
    logic [CODE_W-1:0] code_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] field_w;
    logic [SEG_W-1:0]  pat_w;
    wr_state_e         state_w;

    segwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({sel_b_n, sel_a_n}), .sync_o(sel_s)
    );

    segwr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n_s(sel_s),
        .code_i(code_i), .addr_i(addr_i),
        .commit_o(commit_w), .code_o(code_q), .addr_o(addr_q),
        .state_o(state_w)
    );

    segwr_glyph u_glyph (.code_i(code_q), .seg_o(pat_w));

    // Reversed address: 0 selects the highest field.
    assign field_w = ADDR_W'(DIGITS - 1) - addr_q;

    segwr_bank #(.DIGITS(DIGITS), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we_i(commit_w),
        .field_i(field_w), .pat_i(pat_w), .seg_o(seg_o)
    );
endmodule

// File: rtl/segwr_port_chk.sv
module segwr_port_chk
    import segwr_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    commit,
    input wr_state_e               state,
    input logic [DIGITS*SEG_W-1:0] seg
);
    logic [DIGITS*SEG_W-1:0] seg_prev;
    logic [DIGITS-1:0]       chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_prev <= '0;
        else        seg_prev <= seg;
    end

    always_comb begin
        for (int k = 0; k < DIGITS; k++)
            chg[k] = seg[k*SEG_W +: SEG_W] != seg_prev[k*SEG_W +: SEG_W];
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    a_r1_commit_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit) |-> $past(state == ST_CAPTURE));
    a_r7_one_field: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(seg));
    a_r8_reset_blank: assert property (@(posedge clk)
        !rst_n |=> seg == '0);
endmodule

bind segwr_port segwr_port_chk #(.DIGITS(DIGITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .state(state_w), .seg(seg_o)
);

// File: tb/segwr_port_test.sv
module segwr_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        sel_a_n = 1, sel_b_n = 1;
    logic [3:0]  code_i = 0;
    logic [1:0]  addr_i = 0;
    logic [27:0] seg_o;
    logic [27:0] model = 0;
    int checks = 0, failures = 0, cycles = 0;

    segwr_port uut (.clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
                    .code_i(code_i), .addr_i(addr_i), .seg_o(seg_o));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [6:0] shape(input logic [3:0] c);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h40, 7'h79, 7'h76, 7'h38, 7'h73, 7'h00};
        return t[c];
    endfunction

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0: A first, 1: B first, 2: both together
    task automatic do_write(input logic [1:0] a, input logic [3:0] c, input int mode, input string req);
        logic [27:0] old_v = model;
        @(negedge clk);
        addr_i = a; code_i = c; sel_a_n = 0; sel_b_n = 0;
        repeat (4) @(negedge clk);
        if (mode == 0)      sel_a_n = 1;
        else if (mode == 1) sel_b_n = 1;
        else begin sel_a_n = 1; sel_b_n = 1; end
        model[(3 - a)*7 +: 7] = shape(c);
        repeat (3) @(posedge clk);
        @(negedge clk);
        sel_a_n = 1; sel_b_n = 1;
        check("R9 not after third edge", seg_o, old_v);
        @(negedge clk);
        check(req, seg_o, model);
        code_i = ~c; addr_i = ~a;
        repeat (3) @(negedge clk);
        check("R2 single write", seg_o, model);
    endtask

    task automatic lone_pulse(input bit use_a);
        @(negedge clk);
        code_i = 4'd8; addr_i = 2'd1;
        if (use_a) sel_a_n = 0; else sel_b_n = 0;
        repeat (4) @(negedge clk);
        sel_a_n = 1; sel_b_n = 1;
        repeat (6) @(negedge clk);
        check("R1 lone select ignored", seg_o, model);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R8 blank in reset", seg_o, 28'h0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check("R8 blank after reset", seg_o, 28'h0);
        // R3 address map and R4 binary weight: directed
        do_write(2'd0, 4'd1, 2, "R3 addr0 to top field");
        check("R3 top field", seg_o, {7'h06, 21'h0});
        do_write(2'd3, 4'd8, 0, "R4 bit3 weight");
        check("R3 addr3 to field0", seg_o[6:0], 7'h7F);
        lone_pulse(1);
        lone_pulse(0);
        // full sweep: R5 digits, R6 letters, R7 others kept
        for (int a = 0; a < 4; a++)
            for (int c = 0; c < 16; c++)
                do_write(a[1:0], c[3:0], (a + c) % 3, c < 10 ? "R5 digit shape" : "R6 letter shape");
        for (int i = 0; i < 120; i++) begin
            if ($urandom_range(0, 7) == 0) lone_pulse($urandom_range(0, 1) == 1);
            else do_write(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
                          int'($urandom_range(0, 2)), "R7 addressed field only");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule